// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block timestamps transitions on one external signal. A two-bit select picks one of four input pins. The chosen pin can be inverted, is resynchronised to the block clock and then passes through an optional glitch filter. When the conditioned signal shows the edge or edges requested by the edge mode, the block copies the count supplied by a neighbouring counter into its capture register and raises an edge flag. The flag stays up until software clears it.

The flag drives one of two consumers, chosen by an enable: an interrupt line or a DMA request line. A capture can also send a one-cycle reload request back to the counter. The counter itself lives outside this block. The filter is programmed with a sample period and a sample count. A period of zero removes the filter from the path.

Top module: `incap_unit`

## Requirements
- R1: After reset, `cap_val` is 0 and `edge_flag`, `edge_irq`, `dma_req` and `reload_req` are all low.
- R2: `pin_sel` picks the source from `pins` (index = `pin_sel`). Transitions on the pins that are not selected cause no capture and leave `cap_val` and `edge_flag` unchanged.
- R3: `edge_mode` is applied to the conditioned signal: 0 = no capture, 1 = rising edges, 2 = falling edges, 3 = both edges.
- R4: When `invert` is 1, the pin is inverted before edge detection. Mode 1 then captures on falling edges of the raw pin and mode 2 on rising edges.
- R5: On a capture, `cap_val` takes the value `cnt_val` has at the clock edge where the capture is taken, and `edge_flag` goes high.
- R6: A capture that arrives while `edge_flag` is still set overwrites `cap_val` with the newer count, and the flag stays set.
- R7: A one-cycle `flag_clr` pulse clears `edge_flag` on the next clock. If a capture happens in the same cycle, the set wins.
- R8: With `reload_en` at 1, every capture produces a `reload_req` pulse one cycle wide, in the same cycle that `cap_val` updates. With `reload_en` at 0, no pulse is produced.
- R9: With `dma_en` at 0, `edge_irq` equals `edge_flag` AND `irq_en` and `dma_req` stays low. With `dma_en` at 1, `dma_req` follows `edge_flag` and `edge_irq` stays low.
- R10: With `filt_per` at 0, the filter is bypassed. The conditioned level follows the synchronised pin one clock later.
- R11: With `filt_per` nonzero, the conditioned pin is sampled every `filt_per` clocks. A new level is accepted only after `filt_cnt`+3 consecutive samples show it, so shorter pulses are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Running count from the neighbouring counter |
| pins | input | N_PINS | Candidate input pins |
| pin_sel | input | SEL_W | Index of the pin to watch |
| invert | input | 1 | Invert the selected pin before edge detection |
| edge_mode | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| filt_cnt | input | FCNT_W | Filter sample count (needs value+3 agreeing samples) |
| filt_per | input | FPER_W | Filter sample period in clocks, 0 = bypass |
| flag_clr | input | 1 | Clear the edge flag |
| irq_en | input | 1 | Enable the edge interrupt |
| dma_en | input | 1 | Route the edge flag to the DMA request instead of the interrupt |
| reload_en | input | 1 | Request a counter reload on each capture |
| cap_val | output | CNT_W | Captured count |
| edge_flag | output | 1 | Sticky edge flag |
| edge_irq | output | 1 | Edge interrupt |
| dma_req | output | 1 | Edge DMA request |
| reload_req | output | 1 | One-cycle counter reload request |

## Verification
The hardest situation to reach from the ports is a pulse that the filter must reject. Its length has to fall below `filt_cnt`+3 sample periods and still cover several sample instants. The stimulus holds the pin high for a fixed number of clocks: five clocks against a period of 2 and a count of 1, and two clocks against a period of 1 and a count of 0. The bench then confirms that neither the flag nor the capture register moved. After that, a held level is applied and must be accepted. Overwrite ordering is reached by letting two accepted edges arrive with different counts on `cnt_val` and no clear between them.

// File: rtl/incap_pkg.sv
package incap_pkg;

   typedef enum logic [1:0] {
      CAP_OFF  = 2'd0,
      CAP_RISE = 2'd1,
      CAP_FALL = 2'd2,
      CAP_BOTH = 2'd3
   } cap_mode_e;

   // Number of agreeing samples the filter needs, from the programmed count.
   function automatic int unsigned filt_need(input int unsigned cnt);
      return cnt + 3;
   endfunction

endpackage

// File: rtl/incap_input_cond.sv
module incap_input_cond #(
   parameter int N_PINS      = 4,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pins,
   input  logic [SEL_W-1:0]  pin_sel,
   input  logic              invert,
   output logic              lvl_sync
);

   logic                   picked;
   logic [SYNC_STAGES-1:0] chain;

   assign picked = pins[pin_sel] ^ invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= picked;
         for (int s = 1; s < SYNC_STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign lvl_sync = chain[SYNC_STAGES-1];

endmodule

// File: rtl/incap_glitch_filter.sv
module incap_glitch_filter #(
   parameter int FCNT_W         = 3,
   parameter int FPER_W         = 8,
   parameter bit FILTER_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic [FCNT_W-1:0] filt_cnt,
   input  logic [FPER_W-1:0] filt_per,
   output logic              lvl
);

   localparam int RUN_W = FCNT_W + 2;

   generate
      if (FILTER_PRESENT) begin : g_filter
         logic [FPER_W-1:0] per_cnt;
         logic [RUN_W-1:0]  run;
         logic [RUN_W-1:0]  need;
         logic              bypass;
         logic              tick;

         assign need   = RUN_W'(incap_pkg::filt_need(int'(filt_cnt)));
         assign bypass = (filt_per == '0);
         assign tick   = !bypass && (per_cnt >= filt_per - FPER_W'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_cnt <= '0;
               run     <= '0;
               lvl     <= 1'b0;
            end else if (bypass) begin
               per_cnt <= '0;
               run     <= '0;
               lvl     <= din;
            end else if (tick) begin
               per_cnt <= '0;
               if (din == lvl) begin
                  run <= '0;
               end else if (run + RUN_W'(1) >= need) begin
                  lvl <= din;
                  run <= '0;
               end else begin
                  run <= run + RUN_W'(1);
               end
            end else begin
               per_cnt <= per_cnt + FPER_W'(1);
            end
         end
      end else begin : g_direct
         logic unused_cfg;
         assign unused_cfg = ^{filt_cnt, filt_per};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl <= 1'b0;
            else        lvl <= din;
         end
      end
   endgenerate

endmodule

// File: rtl/incap_edge_detect.sv
module incap_edge_detect (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic [1:0] edge_mode,
   output logic       cap_evt
);

   import incap_pkg::*;

   logic      prev;
   logic      rise;
   logic      fall;
   cap_mode_e mode;

   assign mode = cap_mode_e'(edge_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

   always_comb begin
      unique case (mode)
         CAP_RISE: cap_evt = rise;
         CAP_FALL: cap_evt = fall;
         CAP_BOTH: cap_evt = rise | fall;
         default:  cap_evt = 1'b0;
      endcase
   end

endmodule

// File: rtl/incap_unit.sv
module incap_unit #(
   parameter int CNT_W          = 16,
   parameter int N_PINS         = 4,
   parameter int FCNT_W         = 3,
   parameter int FPER_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit FILTER_PRESENT = 1'b1,
   localparam int SEL_W         = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic [N_PINS-1:0] pins,
   input  logic [SEL_W-1:0]  pin_sel,
   input  logic              invert,
   input  logic [1:0]        edge_mode,
   input  logic [FCNT_W-1:0] filt_cnt,
   input  logic [FPER_W-1:0] filt_per,
   input  logic              flag_clr,
   input  logic              irq_en,
   input  logic              dma_en,
   input  logic              reload_en,
   output logic [CNT_W-1:0]  cap_val,
   output logic              edge_flag,
   output logic              edge_irq,
   output logic              dma_req,
   output logic              reload_req
);

   generate
      if (CNT_W < 1)       begin : g_bad_cnt  $error("CNT_W must be at least 1");       end
      if (N_PINS < 2)      begin : g_bad_pins $error("N_PINS must be at least 2");      end
      if (SYNC_STAGES < 1) begin : g_bad_sync $error("SYNC_STAGES must be at least 1"); end
      if (FPER_W < 1)      begin : g_bad_per  $error("FPER_W must be at least 1");      end
      if (FCNT_W < 1)      begin : g_bad_fcnt $error("FCNT_W must be at least 1");      end
   endgenerate

   logic lvl_sync;
   logic lvl_filt;
   logic cap_evt;

   incap_input_cond #(
      .N_PINS     (N_PINS),
      .SEL_W      (SEL_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (pins),
      .pin_sel (pin_sel),
      .invert  (invert),
      .lvl_sync(lvl_sync)
   );

   incap_glitch_filter #(
      .FCNT_W        (FCNT_W),
      .FPER_W        (FPER_W),
      .FILTER_PRESENT(FILTER_PRESENT)
   ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (lvl_sync),
      .filt_cnt(filt_cnt),
      .filt_per(filt_per),
      .lvl     (lvl_filt)
   );

   incap_edge_detect u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_filt),
      .edge_mode(edge_mode),
      .cap_evt  (cap_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val    <= '0;
         edge_flag  <= 1'b0;
         reload_req <= 1'b0;
      end else begin
         if (cap_evt) cap_val <= cnt_val;
         edge_flag  <= cap_evt | (edge_flag & ~flag_clr);
         reload_req <= cap_evt & reload_en;
      end
   end

   assign dma_req  = edge_flag & dma_en;
   assign edge_irq = edge_flag & irq_en & ~dma_en;

endmodule

// File: rtl/incap_unit_chk.sv
module incap_unit_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_val,
   input logic             flag_clr,
   input logic             reload_en,
   input logic             cap_evt,
   input logic [CNT_W-1:0] cap_val,
   input logic             edge_flag,
   input logic             edge_irq,
   input logic             dma_req,
   input logic             reload_req
);

   a_r5_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> edge_flag && (cap_val == $past(cnt_val)));

   a_r7_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !cap_evt |=> !edge_flag);

   a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && cap_evt |=> edge_flag);

   a_r8_reload_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt && reload_en |=> reload_req);

   a_r8_reload_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |-> edge_flag);

   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      edge_irq |-> edge_flag);

   always_comb begin
      if (rst_n) begin
         a_r9_one_consumer: assert (!(edge_irq && dma_req));
      end
   end

endmodule

bind incap_unit incap_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_val   (cnt_val),
   .flag_clr  (flag_clr),
   .reload_en (reload_en),
   .cap_evt   (cap_evt),
   .cap_val   (cap_val),
   .edge_flag (edge_flag),
   .edge_irq  (edge_irq),
   .dma_req   (dma_req),
   .reload_req(reload_req)
);

// File: tb/test_incap_unit.sv
module test_incap_unit;

   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] cnt_val = '0;
   logic [3:0]       pins = '0;
   logic [1:0]       pin_sel = '0;
   logic             invert = 1'b0;
   logic [1:0]       edge_mode = '0;
   logic [2:0]       filt_cnt = '0;
   logic [7:0]       filt_per = '0;
   logic             flag_clr = 1'b0;
   logic             irq_en = 1'b0;
   logic             dma_en = 1'b0;
   logic             reload_en = 1'b0;
   logic [CNT_W-1:0] cap_val;
   logic             edge_flag, edge_irq, dma_req, reload_req;

   int checks = 0;
   int failures = 0;
   int reloads = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   incap_unit i_incap_unit (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .pins(pins), .pin_sel(pin_sel),
      .invert(invert), .edge_mode(edge_mode), .filt_cnt(filt_cnt), .filt_per(filt_per),
      .flag_clr(flag_clr), .irq_en(irq_en), .dma_en(dma_en), .reload_en(reload_en),
      .cap_val(cap_val), .edge_flag(edge_flag), .edge_irq(edge_irq), .dma_req(dma_req),
      .reload_req(reload_req)
   );

   always @(negedge clk) if (rst_n && reload_req) reloads++;

   // vector: {sel[1:0], invert, mode[1:0], raw edge direction (1 = rising), capture expected}
   localparam logic [6:0] VEC [10] = '{
      {2'd0, 1'b0, 2'd1, 1'b1, 1'b1},
      {2'd1, 1'b0, 2'd1, 1'b0, 1'b0},
      {2'd2, 1'b0, 2'd2, 1'b0, 1'b1},
      {2'd3, 1'b0, 2'd2, 1'b1, 1'b0},
      {2'd0, 1'b1, 2'd1, 1'b0, 1'b1},
      {2'd1, 1'b1, 2'd1, 1'b1, 1'b0},
      {2'd2, 1'b1, 2'd2, 1'b1, 1'b1},
      {2'd3, 1'b0, 2'd3, 1'b1, 1'b1},
      {2'd3, 1'b1, 2'd3, 1'b0, 1'b1},
      {2'd0, 1'b0, 2'd0, 1'b1, 1'b0}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      step(1);
      flag_clr = 1'b0;
      step(1);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [CNT_W-1:0] base;
      int               rel0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      check("R1 cap_val", 32'(cap_val), 0);
      check("R1 edge_flag", 32'(edge_flag), 0);
      check("R1 edge_irq", 32'(edge_irq), 0);
      check("R1 dma_req", 32'(dma_req), 0);
      check("R1 reload_req", 32'(reload_req), 0);

      // Table walk (filter bypassed, R10): R2 select, R3 mode, R4 inversion, R5 capture
      for (int i = 0; i < 10; i++) begin
         logic [CNT_W-1:0] newcnt;
         pin_sel   = VEC[i][6:5];
         invert    = VEC[i][4];
         edge_mode = VEC[i][3:2];
         cnt_val   = CNT_W'(16'h1000 + i);
         pins      = '0;
         pins[VEC[i][6:5]] = ~VEC[i][1];
         step(10);
         clear_flag();
         base   = cap_val;
         newcnt = CNT_W'(16'hA000 + i * 16'h11);
         cnt_val = newcnt;
         pins[VEC[i][6:5]] = VEC[i][1];
         step(10);
         check("R3/R4/R10 flag", 32'(edge_flag), 32'(VEC[i][0]));
         check("R2/R5 cap_val", 32'(cap_val), VEC[i][0] ? 32'(newcnt) : 32'(base));
      end

      // R2 unselected pins ignored
      pin_sel = 2'd0; invert = 1'b0; edge_mode = 2'd3; pins = '0;
      step(10);
      clear_flag();
      base = cap_val;
      cnt_val = 16'h5555;
      pins[3:1] = 3'b111;
      step(10);
      check("R2 flag unselected", 32'(edge_flag), 0);
      check("R2 cap unselected", 32'(cap_val), 32'(base));
      pins = '0;

      // R6 overwrite without clear
      edge_mode = 2'd1;
      step(10);
      clear_flag();
      cnt_val = 16'h1111; pins[0] = 1'b1; step(10);
      pins[0] = 1'b0; step(10);
      cnt_val = 16'h2222; pins[0] = 1'b1; step(10);
      check("R6 cap overwritten", 32'(cap_val), 32'h2222);
      check("R6 flag kept", 32'(edge_flag), 1);

      // R9 interrupt versus DMA routing
      irq_en = 1'b1; dma_en = 1'b0; step(1);
      check("R9 irq", 32'(edge_irq), 1);
      check("R9 dma off", 32'(dma_req), 0);
      dma_en = 1'b1; step(1);
      check("R9 irq suppressed", 32'(edge_irq), 0);
      check("R9 dma", 32'(dma_req), 1);
      irq_en = 1'b0; dma_en = 1'b0;

      // R7 clear
      clear_flag();
      check("R7 flag cleared", 32'(edge_flag), 0);

      // R8 reload request
      pins[0] = 1'b0; step(10);
      rel0 = reloads;
      reload_en = 1'b1;
      pins[0] = 1'b1; step(10);
      check("R8 one reload pulse", 32'(reloads - rel0), 1);
      reload_en = 1'b0;
      pins[0] = 1'b0; step(10);
      pins[0] = 1'b1; step(10);
      check("R8 no reload when off", 32'(reloads - rel0), 1);

      // R11 filter, period 2, count 1: four agreeing samples needed
      filt_per = 8'd2; filt_cnt = 3'd1; edge_mode = 2'd3; pins = '0;
      step(30);
      clear_flag();
      base = cap_val;
      cnt_val = 16'h7777;
      pins[0] = 1'b1; step(5); pins[0] = 1'b0; step(30);
      check("R11 short pulse flag", 32'(edge_flag), 0);
      check("R11 short pulse cap", 32'(cap_val), 32'(base));
      pins[0] = 1'b1; step(30);
      check("R11 held level flag", 32'(edge_flag), 1);
      check("R11 held level cap", 32'(cap_val), 32'h7777);

      // R11 filter, period 1, count 0: three samples needed, two-clock pulse dropped
      filt_per = 8'd1; filt_cnt = 3'd0; pins = '0;
      step(30);
      clear_flag();
      base = cap_val;
      cnt_val = 16'h8888;
      pins[0] = 1'b1; step(2); pins[0] = 1'b0; step(20);
      check("R11 two-clock pulse flag", 32'(edge_flag), 0);
      check("R11 two-clock pulse cap", 32'(cap_val), 32'(base));

      done = 1'b1;
      finish_run();
   end

endmodule